// File: doc/BRIEF.md
# Core Module System Control Registers

This block is the bank of control and status words that a processor core module exposes on its local register bus. The bus carries a 32-bit word and a word index. Reads are combinational in the cycle of the access. Writes take effect at the clock edge that ends the access.

The bank holds four kinds of state:
- **Key-protected oscillator settings.** A 16-bit key must first open these words before they accept a write.
- **A control word.** It drives an LED, the boot-memory remap select and a registered one-cycle system reset request.
- **Memory setup words.** These are an SDRAM configuration word and an init word. The SDRAM word takes a size code at reset, chosen from a memory-size parameter.
- **Flag words.** There are two banks, volatile and non-volatile, each with its own set and clear addresses.

The bank also holds a free-running reference counter and fixed identity and status words.

An access to an index the block does not decode raises a one-cycle error flag on the next cycle.

Top module: `cm_sysctrl`

## Requirements
- R1: Reads return fixed values at these word indices:
  - index 0 returns 0x411A3001;
  - index 1 returns 0;
  - index 4 returns 0x00100000;
  - indices 32 to 35 return 0 and ignore writes without raising the error flag.
- R2: A write to index 5 stores only bits 15:0 of the data as the key. A read of index 5 returns the key in bits 15:0, and bit 16 is set exactly when the key equals 0xA05F. The key resets to 0.
- R3: The oscillator word (index 2) and the auxiliary oscillator word (index 7) take a write only while the key equals 0xA05F. A write at any other time leaves the word unchanged.
- R4: A write to the control word (index 3) stores only bits 0 and 2. Bit 0 drives `led_o` and bit 2 drives `remap_o` (1 = RAM at address zero, 0 = boot flash). A read returns only those two bits, so bit 3 always reads 0.
- R5: A control write with data bit 3 set makes `sys_rst_req_o` high for exactly the one cycle after the write edge. A control write with bit 3 clear leaves it low.
- R6: Flag words behave as follows:
  - a write to index 12 ORs the data into the flags;
  - a write to index 13 clears the flag bits that are set in the data;
  - indices 14 and 15 do the same for the non-volatile flags;
  - reads of 12 and 14 return the current flags;
  - the two banks are independent.
- R7: After reset the words read as follows:
  - oscillator 0x01000048;
  - auxiliary oscillator 0x0007FEFF;
  - init 0x00000112;
  - SDRAM 0x00011122 ORed with a size code of 0x10 (MEM_MB ≥ 256), 0x0C (≥ 128), 0x08 (≥ 64), 0x04 (≥ 32) or 0 otherwise. With the default MEM_MB = 128 the SDRAM word is 0x0001112E;
  - control, key and flags are 0.
- R8: Writes to indices 8 (SDRAM) and 9 (init) store all 32 bits.
- R9: The 32-bit reference counter at index 10 is 0 after reset. It advances by exactly one every PRESCALE clock cycles and wraps.
- R10: A read or write at any index outside the decoded set raises `bus_err_o` for one cycle, on the cycle after the access. The decoded set for reads and for writes differs:
  - reads of indices 6, 11, 13 and 15 are undefined;
  - writes to indices 0, 1, 4 and 10 are undefined.
  
  An undefined read returns 0, and an undefined write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational, 0 if not a valid read) |
| bus_err_o | output | 1 | One-cycle flag after an undefined access |
| led_o | output | 1 | LED level (control bit 0) |
| remap_o | output | 1 | Remap select (control bit 2) |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A single control write can carry the reset-request bit together with new LED and remap values, so the pulse and the two level outputs change at the same edge. The bench issues writes of 0x8 and 0xD and judges the result in the next low clock phase:
- the pulse is high with the new LED and remap levels;
- a read of the control word returns bits 0 and 2 without bit 3;
- the pulse is gone one cycle later.

A counter read held across several prescaler ticks is judged by exact tick arithmetic over a multiple of PRESCALE cycles.

// File: rtl/cmsc_pkg.sv
package cmsc_pkg;

  // Word indices with behavioural meaning.
  localparam int unsigned WA_ID      = 0;
  localparam int unsigned WA_PROC    = 1;
  localparam int unsigned WA_OSC     = 2;
  localparam int unsigned WA_CTRL    = 3;
  localparam int unsigned WA_STAT    = 4;
  localparam int unsigned WA_LOCK    = 5;
  localparam int unsigned WA_AUX     = 7;
  localparam int unsigned WA_SDRAM   = 8;
  localparam int unsigned WA_INIT    = 9;
  localparam int unsigned WA_REFCNT  = 10;
  localparam int unsigned WA_FLG_SET = 12;
  localparam int unsigned WA_FLG_CLR = 13;
  localparam int unsigned WA_NVF_SET = 14;
  localparam int unsigned WA_NVF_CLR = 15;
  localparam int unsigned WA_VOLT_LO = 32;
  localparam int unsigned WA_VOLT_HI = 35;

  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  localparam int unsigned CB_LED   = 0;
  localparam int unsigned CB_REMAP = 2;
  localparam int unsigned CB_RESET = 3;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
  } acc_t;

  function automatic logic [31:0] sdram_size_code(int unsigned mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/cmsc_keyed_regs.sv
module cmsc_keyed_regs
  import cmsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        lock_we_i,
  input  logic        osc_we_i,
  input  logic        aux_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lock_rd_o,
  output logic [31:0] osc_o,
  output logic [31:0] aux_o
);

  logic [15:0] key_q, key_d;
  logic [31:0] osc_q, osc_d, aux_q, aux_d;
  logic        unlocked;
  logic        key_en, osc_en, aux_en;

  assign unlocked = (key_q == UNLOCK_KEY);

  always_comb begin
    key_en = lock_we_i;
    osc_en = osc_we_i & unlocked;
    aux_en = aux_we_i & unlocked;
    key_d  = wdata_i[15:0];
    osc_d  = wdata_i;
    aux_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      osc_q <= OSC_RST;
      aux_q <= AUX_RST;
    end else begin
      if (key_en) key_q <= key_d;
      if (osc_en) osc_q <= osc_d;
      if (aux_en) aux_q <= aux_d;
    end
  end

  assign lock_rd_o = {15'd0, unlocked, key_q};
  assign osc_o     = osc_q;
  assign aux_o     = aux_q;

  // R3: locked writes leave the oscillator words untouched
  a_r3_osc_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_we_i && !lock_rd_o[16]) |=> $stable(osc_o));
  a_r3_aux_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_we_i && !lock_rd_o[16]) |=> $stable(aux_o));
  // R2: key readback reflects the written low half
  a_r2_key_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_we_i |=> (lock_rd_o[15:0] == $past(wdata_i[15:0])));

endmodule

// File: rtl/cmsc_setclr_reg.sv
module cmsc_setclr_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q, q_d, set_mask, clr_mask;
  logic             en;

  always_comb begin
    set_mask = set_we_i ? wdata_i : '0;
    clr_mask = clr_we_i ? wdata_i : '0;
    q_d      = (q_q | set_mask) & ~clr_mask;
    en       = set_we_i | clr_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (en)  q_q <= q_d;
  end

  assign q_o = q_q;

  // R6: set bits appear, cleared bits vanish, nothing else moves
  a_r6_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  a_r6_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((q_o & $past(wdata_i)) == '0));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(q_o));

endmodule

// File: rtl/cmsc_ctrl.sv
module cmsc_ctrl
  import cmsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_rd_o,
  output logic        led_o,
  output logic        remap_o,
  output logic        rst_req_o
);

  logic led_q, led_d, remap_q, remap_d, req_q, req_d;

  always_comb begin
    led_d   = wdata_i[CB_LED];
    remap_d = wdata_i[CB_REMAP];
    req_d   = ctrl_we_i & wdata_i[CB_RESET];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        led_q   <= led_d;
        remap_q <= remap_d;
      end
      req_q <= req_d;
    end
  end

  always_comb begin
    ctrl_rd_o           = '0;
    ctrl_rd_o[CB_LED]   = led_q;
    ctrl_rd_o[CB_REMAP] = remap_q;
  end

  assign led_o     = led_q;
  assign remap_o   = remap_q;
  assign rst_req_o = req_q;

  // R5: request pulse follows exactly the writes carrying the reset bit
  a_r5_req_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[CB_RESET]) |=> rst_req_o);
  a_r5_no_req_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && wdata_i[CB_RESET]) |=> !rst_req_o);
  // R4: outputs move only on a control write
  a_r4_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> ($stable(led_o) && $stable(remap_o)));

endmodule

// File: rtl/cmsc_refcnt.sv
module cmsc_refcnt #(
  parameter int unsigned PRESCALE = 3,
  parameter int unsigned CNT_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] count_o
);

  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (PRESCALE <= 1) begin : g_no_div
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] ps_q, ps_d;
      assign tick = (ps_q == PS_LAST);
      assign ps_d = tick ? '0 : ps_q + 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ps_q <= '0;
        else         ps_q <= ps_d;
      end
    end
  endgenerate

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R9: the counter only ever steps by one
  a_r9_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/cm_sysctrl.sv
module cm_sysctrl
  import cmsc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned MEM_MB   = 128,
  parameter int unsigned PRESCALE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o,
  output logic              led_o,
  output logic              remap_o,
  output logic              sys_rst_req_o
);

  localparam int unsigned CNT_W     = 32;
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

  logic [31:0] widx;
  acc_t        dec;
  logic        rd_acc, wr_acc;
  logic        osc_we, ctrl_we, lock_we, aux_we, sdram_we, init_we;
  logic        flg_set, flg_clr, nvf_set, nvf_clr;
  logic [31:0] lock_rd, osc_w, aux_w, ctrl_rd, flags_w, nvflags_w, count_w;
  logic [31:0] sdram_q, init_q, rmux;
  logic        err_q, err_d;
  logic        in_volt;

  assign widx    = 32'(bus_addr_i);
  assign rd_acc  = bus_sel_i & ~bus_wr_i;
  assign wr_acc  = bus_sel_i &  bus_wr_i;
  assign in_volt = (widx >= WA_VOLT_LO) && (widx <= WA_VOLT_HI);

  // Decode of which indices are defined per direction.
  always_comb begin
    dec = '{rd_ok: 1'b0, wr_ok: 1'b0};
    unique case (widx)
      WA_ID, WA_PROC, WA_STAT, WA_REFCNT:  dec.rd_ok = 1'b1;
      WA_OSC, WA_CTRL, WA_LOCK, WA_AUX,
      WA_SDRAM, WA_INIT,
      WA_FLG_SET, WA_NVF_SET:              dec = '{rd_ok: 1'b1, wr_ok: 1'b1};
      WA_FLG_CLR, WA_NVF_CLR:              dec.wr_ok = 1'b1;
      default: if (in_volt)                dec = '{rd_ok: 1'b1, wr_ok: 1'b1};
    endcase
  end

  always_comb begin
    osc_we   = wr_acc && (widx == WA_OSC);
    ctrl_we  = wr_acc && (widx == WA_CTRL);
    lock_we  = wr_acc && (widx == WA_LOCK);
    aux_we   = wr_acc && (widx == WA_AUX);
    sdram_we = wr_acc && (widx == WA_SDRAM);
    init_we  = wr_acc && (widx == WA_INIT);
    flg_set  = wr_acc && (widx == WA_FLG_SET);
    flg_clr  = wr_acc && (widx == WA_FLG_CLR);
    nvf_set  = wr_acc && (widx == WA_NVF_SET);
    nvf_clr  = wr_acc && (widx == WA_NVF_CLR);
  end

  cmsc_keyed_regs u_keyed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_we_i (lock_we),
    .osc_we_i  (osc_we),
    .aux_we_i  (aux_we),
    .wdata_i   (bus_wdata_i),
    .lock_rd_o (lock_rd),
    .osc_o     (osc_w),
    .aux_o     (aux_w)
  );

  cmsc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .wdata_i   (bus_wdata_i),
    .ctrl_rd_o (ctrl_rd),
    .led_o     (led_o),
    .remap_o   (remap_o),
    .rst_req_o (sys_rst_req_o)
  );

  cmsc_setclr_reg #(.WIDTH(32)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (flg_set),
    .clr_we_i (flg_clr),
    .wdata_i  (bus_wdata_i),
    .q_o      (flags_w)
  );

  cmsc_setclr_reg #(.WIDTH(32)) u_nvflags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (nvf_set),
    .clr_we_i (nvf_clr),
    .wdata_i  (bus_wdata_i),
    .q_o      (nvflags_w)
  );

  cmsc_refcnt #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_refcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_o (count_w)
  );

  // Plain full-width memory setup words.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
    end else begin
      if (sdram_we) sdram_q <= bus_wdata_i;
      if (init_we)  init_q  <= bus_wdata_i;
    end
  end

  // Read mux; voltage words and unknown indices fall to zero.
  always_comb begin
    unique case (widx)
      WA_ID:      rmux = ID_WORD;
      WA_OSC:     rmux = osc_w;
      WA_CTRL:    rmux = ctrl_rd;
      WA_STAT:    rmux = STAT_WORD;
      WA_LOCK:    rmux = lock_rd;
      WA_AUX:     rmux = aux_w;
      WA_SDRAM:   rmux = sdram_q;
      WA_INIT:    rmux = init_q;
      WA_REFCNT:  rmux = count_w;
      WA_FLG_SET: rmux = flags_w;
      WA_NVF_SET: rmux = nvflags_w;
      default:    rmux = '0;
    endcase
  end

  assign bus_rdata_o = (rd_acc && dec.rd_ok) ? rmux : '0;

  assign err_d = bus_sel_i & ~(bus_wr_i ? dec.wr_ok : dec.rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign bus_err_o = err_q;

  // R10: an error flag always traces back to an access one cycle earlier
  a_r10_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(bus_sel_i));
  // R10: undefined reads return zero
  a_r10_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !dec.rd_ok) |-> (bus_rdata_o == '0));
  // R1: identity word is constant
  a_r1_id_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && (widx == WA_ID)) |-> (bus_rdata_o == 32'h411A_3001));
  // R8: full-width store of the SDRAM word
  a_r8_sdram_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdram_we |=> (sdram_q == $past(bus_wdata_i)));

endmodule

// File: tb/tb_cm_sysctrl.sv
`timescale 1ns/1ps
module tb_cm_sysctrl;

  localparam int unsigned AW = 6;
  localparam int unsigned PS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err, led, remap, rreq;

  int checks = 0;
  int errors = 0;
  logic          last_err, last_req;

  always #4 clk = ~clk;

  cm_sysctrl #(.ADDR_W(AW), .MEM_MB(128), .PRESCALE(PS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_err_o(err), .led_o(led), .remap_o(remap), .sys_rst_req_o(rreq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    last_err = err; last_req = rreq;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk);
    last_err = err;
    sel = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    bus_rd(0, d);  chk("R1 id", d, 32'h411A3001);
    bus_rd(1, d);  chk("R1 proc", d, 0);
    bus_rd(4, d);  chk("R1 status", d, 32'h00100000);
    bus_rd(2, d);  chk("R7 osc reset", d, 32'h01000048);
    bus_rd(7, d);  chk("R7 aux reset", d, 32'h0007FEFF);
    bus_rd(9, d);  chk("R7 init reset", d, 32'h00000112);
    bus_rd(8, d);  chk("R7 sdram reset with size code", d, 32'h0001112E);
    bus_rd(3, d);  chk("R7 ctrl reset", d, 0);
    bus_rd(5, d);  chk("R7 key reset", d, 0);
    bus_rd(12, d); chk("R7 flags reset", d, 0);
    chk("R1 no error on defined read", {31'd0, last_err}, 0);
  endtask

  task automatic t_lock_osc();
    logic [31:0] d;
    bus_wr(2, 32'h12345678);
    bus_rd(2, d);  chk("R3 locked osc write ignored", d, 32'h01000048);
    bus_wr(5, 32'hFFFFA05F);
    bus_rd(5, d);  chk("R2 unlocked readback", d, 32'h0001A05F);
    bus_wr(2, 32'h12345678);
    bus_rd(2, d);  chk("R3 unlocked osc write", d, 32'h12345678);
    bus_wr(7, 32'h0000CAFE);
    bus_rd(7, d);  chk("R3 unlocked aux write", d, 32'h0000CAFE);
    bus_wr(5, 32'hABCD1234);
    bus_rd(5, d);  chk("R2 low half stored", d, 32'h00001234);
    bus_wr(7, 32'h1);
    bus_rd(7, d);  chk("R3 relocked aux ignored", d, 32'h0000CAFE);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_wr(3, 32'hFFFFFFF5);
    chk("R5 no request without bit 3", {31'd0, last_req}, 0);
    chk("R4 led set", {31'd0, led}, 1);
    chk("R4 remap set", {31'd0, remap}, 1);
    bus_rd(3, d);  chk("R4 only bits 0 and 2 read", d, 32'h5);
    bus_wr(3, 32'h8);
    chk("R5 request pulse", {31'd0, last_req}, 1);
    chk("R4 led cleared by same write", {31'd0, led}, 0);
    chk("R4 remap cleared by same write", {31'd0, remap}, 0);
    @(negedge clk);
    chk("R5 pulse lasts one cycle", {31'd0, rreq}, 0);
    bus_wr(3, 32'hD);
    chk("R5 pulse with level change", {31'd0, last_req}, 1);
    chk("R4 led with pulse", {31'd0, led}, 1);
    chk("R4 remap with pulse", {31'd0, remap}, 1);
    bus_rd(3, d);  chk("R4 bit 3 reads zero", d, 32'h5);
    chk("R5 pulse ended", {31'd0, rreq}, 0);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    bus_wr(12, 32'hF0);
    bus_rd(12, d); chk("R6 flags set", d, 32'hF0);
    bus_wr(12, 32'h3);
    bus_rd(12, d); chk("R6 flags or", d, 32'hF3);
    bus_wr(13, 32'h30);
    bus_rd(12, d); chk("R6 flags clear", d, 32'hC3);
    bus_wr(14, 32'hA5A5);
    bus_rd(14, d); chk("R6 nv flags set", d, 32'hA5A5);
    bus_rd(12, d); chk("R6 banks independent", d, 32'hC3);
    bus_wr(15, 32'hFFFF);
    bus_rd(14, d); chk("R6 nv flags clear", d, 0);
  endtask

  task automatic t_mem_words();
    logic [31:0] d;
    bus_wr(8, 32'hDEADBEEF);
    bus_rd(8, d);  chk("R8 sdram full write", d, 32'hDEADBEEF);
    bus_wr(9, 32'h0);
    bus_rd(9, d);  chk("R8 init full write", d, 0);
  endtask

  task automatic t_volt_err();
    logic [31:0] d;
    bus_wr(33, 32'hFFFF);
    chk("R1 volt write no error", {31'd0, last_err}, 0);
    bus_rd(33, d); chk("R1 volt reads zero", d, 0);
    bus_rd(6, d);  chk("R10 undefined read data", d, 0);
    chk("R10 undefined read error", {31'd0, last_err}, 1);
    @(negedge clk);
    chk("R10 error one cycle", {31'd0, err}, 0);
    bus_wr(0, 32'h0);
    chk("R10 write to read-only index error", {31'd0, last_err}, 1);
    bus_rd(0, d);  chk("R10 read-only word unchanged", d, 32'h411A3001);
    bus_rd(13, d); chk("R10 clear index not readable", {31'd0, last_err}, 1);
  endtask

  task automatic t_counter();
    logic [31:0] c1, c2;
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = AW'(10);
    #1 c1 = rdata;
    repeat (10 * PS) @(negedge clk);
    #1 c2 = rdata;
    chk("R9 ten ticks over 10*PRESCALE cycles", c2 - c1, 10);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sel = 1'b1; wr = 1'b0; addr = AW'(10);
    #1;
    chk("R9 counter zero after reset", rdata, 0);
    chk("R5 no request at reset", {31'd0, rreq}, 0);
    chk("R4 led low at reset", {31'd0, led}, 0);
    chk("R10 no error at reset", {31'd0, err}, 0);
    @(negedge clk);
    sel = 1'b0;
    t_reset_state();
    t_lock_osc();
    t_ctrl();
    t_flags();
    t_mem_words();
    t_volt_err();
    t_counter();
    finish_run();
  end

endmodule